// File: doc/BRIEF.md
# Lockable GPIO input crossbar

This block routes GPIO pins to sixteen crossbar outputs. Each output has its own 16-bit select register. A select code below the pin count routes that pin to the output. The top code forces the output low. Every other code forces it high. The power-on code is one of the "high" codes, so all outputs idle at logic 1 until software routes them.

Software reaches the registers over a simple word-addressed bus with these signals: address, write data, write strobe, read strobe and read data. Reads are combinational. A write changes state on the clock edge that samples the write strobe. A write only lands while the protection-enable input is high. A separate lock word holds one sticky bit per output. Setting a bit freezes that output's select register until the next system reset. The outputs are combinational from the select registers and the pins, so a new code shows on the output in the cycle after the write edge.

Top module: `gpio_route_xbar`

## Requirements
- R1: After reset:
  - every select register reads 0xFFFE;
  - the lock word (offset 0x1E) reads 0;
  - all sixteen outputs are 1, whatever the pins are doing.
- R2: When select register k (word offset k, 0..15) holds a code N below NUM_PINS, output k follows pin N. This takes effect from the cycle after the write edge.
- R3: A select code of 0xFFFF drives the output to 0, whatever the pins are doing.
- R4: Every other code at or above NUM_PINS drives the output to 1. This includes 0xFFFD, 0xFFFE, codes just above the last pin, and codes with the top bit set. The comparison uses all 16 bits.
- R5: A write strobe while the protection-enable input is low changes no select register and no lock bit.
- R6: Lock word behaviour:
  - Writing 1 to bit k of the lock word (offset 0x1E) sets lock k.
  - Writing 0 leaves a lock bit unchanged.
  - Only reset clears a lock bit.
  - Bits 31..16 of the lock word always read 0.
- R7: A locked select register ignores writes but still reads back its held value. Other unlocked registers stay writable.
- R8: Reads of reserved offsets (0x10..0x1D, 0x1F) return 0. Writes to them change no register.
- R9: A select register reads back its 16-bit code in bits 15..0, with bits 31..16 as 0. Read data is 0 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| prot_en | input | 1 | Write protection enable; writes land only while high |
| reg_addr | input | ADDR_W (5) | Word offset of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W (32) | Combinational read data, 0 when not reading |
| gpio_in | input | NUM_PINS (64) | GPIO pin levels |
| xbar_out | output | NUM_OUT (16) | Crossbar outputs |

## Verification
The routing is tried with sixteen distinct pin codes under two complementary pin patterns. An output that picked the wrong pin, or that did not follow its pin, disagrees in at least one of the two. The forcing codes are set against all-zero pins and then all-one pins. This separates a forced 0 or a forced 1 from a routed pin and from one another. The boundary codes are the last legal pin, the first code past it, and a code with only the top bit set. These show whether the range check uses the full code width. Lock, protection and reserved-offset writes are each followed by reads of the registers they might have disturbed, including the aliased offset 0x10.

// File: rtl/gpio_route_xbar.sv
module gpio_route_xbar #(
  parameter int NUM_PINS = 64,
  parameter int NUM_OUT  = 16,
  parameter int SEL_W    = 16,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prot_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_we,
  input  logic                reg_re,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_OUT-1:0]  xbar_out
);
  localparam int IDX_W = $clog2(NUM_OUT);
  localparam int PIN_W = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(30);
  localparam logic [ADDR_W:0]   OUT_LIM   = (ADDR_W+1)'(NUM_OUT);
  localparam logic [SEL_W:0]    PIN_LIM   = (SEL_W+1)'(NUM_PINS);
  localparam logic [SEL_W-1:0]  RST_CODE  = {{(SEL_W-1){1'b1}}, 1'b0};

  logic [NUM_OUT-1:0][SEL_W-1:0] sel_q;
  logic [NUM_OUT-1:0]            lock_q;

  wire [IDX_W-1:0] idx     = reg_addr[IDX_W-1:0];
  wire             sel_hit = {1'b0, reg_addr} < OUT_LIM;
  wire             wr_ok   = reg_we & prot_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= {NUM_OUT{RST_CODE}};
      lock_q <= '0;
    end else if (wr_ok) begin
      if (sel_hit && !lock_q[idx]) sel_q[idx] <= reg_wdata[SEL_W-1:0];
      if (reg_addr == LOCK_ADDR)   lock_q <= lock_q | reg_wdata[NUM_OUT-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      if (sel_hit)                     reg_rdata = DATA_W'(sel_q[idx]);
      else if (reg_addr == LOCK_ADDR)  reg_rdata = DATA_W'(lock_q);
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_route
    wire [SEL_W-1:0] code = sel_q[i];
    assign xbar_out[i] = ({1'b0, code} < PIN_LIM) ? gpio_in[code[PIN_W-1:0]]
                                                  : (code != '1);
  end
endmodule

module gpio_route_xbar_chk #(
  parameter int NUM_OUT = 16,
  parameter int SEL_W   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          prot_en,
  input logic                          reg_re,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_rdata,
  input logic [NUM_OUT-1:0]            xbar_out,
  input logic [NUM_OUT-1:0][SEL_W-1:0] sel_q,
  input logic [NUM_OUT-1:0]            lock_q
);
  // R1
  reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lock_q == '0) && (&xbar_out));

  // R5
  no_prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> $stable(sel_q) && $stable(lock_q));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & $past(lock_q)) == $past(lock_q));

  // R6
  lock_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == ADDR_W'(30)) |-> reg_rdata[DATA_W-1:16] == '0);

  // R8
  reserved_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(NUM_OUT) && reg_addr != ADDR_W'(30)) |-> reg_rdata == '0);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> $stable(sel_q[i]));

    // R3
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] == '1) |-> !xbar_out[i]);
  end
endmodule

bind gpio_route_xbar gpio_route_xbar_chk #(
  .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .xbar_out(xbar_out),
  .sel_q(sel_q), .lock_q(lock_q)
);

// File: tb/gpio_route_xbar_tb_top.sv
`timescale 1ns/1ps
module gpio_route_xbar_tb_top;
  localparam int NP = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        prot_en = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 0;
  logic        reg_re = 0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [15:0] xbar_out;

  always #2 clk = ~clk;

  gpio_route_xbar #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .gpio_in(gpio_in), .xbar_out(xbar_out));

  typedef struct { bit is_rd; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] shadow [16];
  logic [15:0] shadow_lock;

  function automatic logic [15:0] model_out();
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      if (int'(shadow[i]) < NP) r[i] = gpio_in[shadow[i]];
      else r[i] = (shadow[i] != 16'hFFFF);
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) shadow[i] = 16'hFFFE;
    shadow_lock = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit prot);
    reg_addr = a; reg_wdata = d; reg_we = 1; prot_en = prot;
    if (prot) begin
      if (a < 16 && !shadow_lock[a[3:0]]) shadow[a[3:0]] = d[15:0];
      if (a == 5'h1E) shadow_lock = shadow_lock | d[15:0];
    end
    @(posedge clk); #1;
    reg_we = 0; prot_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input bit re, input logic [31:0] e, input string tag);
    reg_addr = a; reg_re = re;
    q.push_back('{1'b1, e, tag});
    @(posedge clk); #1;
    reg_re = 0;
  endtask

  task automatic chk_out(input string tag);
    q.push_back('{1'b0, {16'b0, model_out()}, tag});
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_rd ? reg_rdata : {16'b0, xbar_out};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0; model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    gpio_in = '0;
    chk_out("R1 outputs high after reset");
    rd(5'h00, 1, 32'h0000FFFE, "R1 select reset code");
    rd(5'h0F, 1, 32'h0000FFFE, "R1 last select reset code");
    rd(5'h1E, 1, 32'h0, "R1 lock word reset");

    // R5 protection low blocks writes
    wr(5'h00, 32'h5, 0);
    wr(5'h1E, 32'hFFFF, 0);
    rd(5'h00, 1, 32'h0000FFFE, "R5 select unchanged");
    rd(5'h1E, 1, 32'h0, "R5 lock unchanged");

    // R2 routing under two patterns
    for (int i = 0; i < 16; i++) wr(5'(i), 32'(i * 3 + 1), 1);
    gpio_in = 64'hA5A5_5A5A_0F0F_F0F0;
    chk_out("R2 routing pattern A");
    gpio_in = ~64'hA5A5_5A5A_0F0F_F0F0;
    chk_out("R2 routing pattern B");
    // R9 readback
    rd(5'h03, 1, 32'h0000000A, "R9 select readback");
    rd(5'h03, 0, 32'h0, "R9 read data zero without strobe");

    // R3 / R4 forcing and boundary codes
    wr(5'h05, 32'hFFFF, 1);
    wr(5'h06, 32'hFFFD, 1);
    wr(5'h07, 32'hFFFE, 1);
    wr(5'h08, 32'd64, 1);
    wr(5'h09, 32'h8000, 1);
    wr(5'h0A, 32'd63, 1);
    gpio_in = '0;
    chk_out("R4 high codes with pins low");
    gpio_in = '1;
    chk_out("R3 force-low code with pins high");
    rd(5'h09, 1, 32'h00008000, "R4 top-bit code readback");

    // R8 reserved offsets
    wr(5'h10, 32'h1234, 1);
    wr(5'h1F, 32'hFFFF_FFFF, 1);
    rd(5'h10, 1, 32'h0, "R8 reserved read 0x10");
    rd(5'h1D, 1, 32'h0, "R8 reserved read 0x1D");
    rd(5'h1F, 1, 32'h0, "R8 reserved read 0x1F");
    rd(5'h00, 1, 32'h1, "R8 select 0 not aliased");
    rd(5'h1E, 1, 32'h0, "R8 lock untouched by reserved write");

    // R6 lock set-only
    wr(5'h1E, 32'hFFFF_0003, 1);
    rd(5'h1E, 1, 32'h3, "R6 lock set, upper bits zero");
    wr(5'h1E, 32'h0, 1);
    rd(5'h1E, 1, 32'h3, "R6 zero write no effect");

    // R7 locked select ignores writes
    wr(5'h00, 32'h20, 1);
    wr(5'h01, 32'h21, 1);
    wr(5'h02, 32'h22, 1);
    rd(5'h00, 1, 32'h1, "R7 locked select 0 held");
    rd(5'h01, 1, 32'h4, "R7 locked select 1 held");
    rd(5'h02, 1, 32'h22, "R7 unlocked select 2 written");
    gpio_in = 64'h0000_0004_0000_0002;
    chk_out("R7 outputs after locked writes");

    // R1 reset clears locks
    do_reset();
    rd(5'h1E, 1, 32'h0, "R1 lock cleared by reset");
    rd(5'h00, 1, 32'h0000FFFE, "R1 select restored by reset");
    chk_out("R1 outputs high after second reset");

    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule